// File: doc/BRIEF.md
# Two-Register Stack-Top Cache

This unit sits at the top of a stack-oriented datapath. The two uppermost stack entries are kept in two fixed registers, each with its own valid bit. Register A is the top and register B is the entry just under it. Everything deeper lives in an external memory, addressed by a stack pointer that names the topmost entry held there. Commands arrive over a valid/ready handshake: push an operand, pop the top, or add the top two entries.

The registers are filled lazily. Nothing is read until an add needs an operand that is not cached. A register is written out to memory only when a push finds both registers occupied. A sum lands in B and A is then marked empty, so no value ever moves for its own sake. All memory traffic goes through one request/acknowledge port, one word at a time. A command that needs more entries than the registers and memory hold together is dropped and flagged.

Top module: `stack_top_cache`

## Requirements
- R1: After reset, topValid is 0, spOut is all ones (the memory holds no entries), cmdReady is 1, underflow is 0 and memReq is 0.
- R2: The opcode is encoded as cmdOp 0 = push, 1 = pop, 2 = add. A push that finds at most one register valid completes without any memory access. It makes cmdData the top value and leaves the entry that was on top directly beneath it.
- R3: A push that finds both registers valid first does one memory write of B to address spOut+1, then increments spOut. The new top is cmdData and the old top sits below it.
- R4: A pop that finds at least one valid register discards the current top without any memory access. The entry below becomes the top if it is cached; otherwise topValid falls to 0.
- R5: A pop that finds no valid register while the memory holds entries decrements spOut, performs no memory access and leaves topValid at 0.
- R6: An add whose two operands are both cached performs no memory access. It leaves the sum of the top two entries, modulo 2^DATA_W, as the single cached top value.
- R7: An add with missing operands first reads each missing entry from memory at address spOut, decrementing spOut after every read. It uses one read when one operand is cached and two reads when none is, and the sum is taken in stack order.
- R8: A pop on an empty stack, or an add on a stack with fewer than two entries, is accepted and dropped. It raises underflow for exactly one cycle after acceptance, makes no memory access and changes no state.
- R9: cmdReady is 0 throughout any fill or spill. memReq, memWe and memAddr stay stable until memAck.
- R10: cmdOp 3 is accepted and has no effect on the top value, the stack pointer or memory.
- R11: topValid is 1 exactly when at least one register is valid, and topData then shows the top of the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command can be accepted |
| cmdOp | input | 2 | Opcode: 0 push, 1 pop, 2 add, 3 no operation |
| cmdData | input | DATA_W | Operand for push |
| topValid | output | 1 | topData holds a cached top entry |
| topData | output | DATA_W | Current top of stack |
| underflow | output | 1 | One-cycle pulse for a dropped command |
| spOut | output | ADDR_W | Stack pointer (address of topmost memory entry) |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Write data |
| memAck | input | 1 | Memory completes the request this cycle |
| memRdata | input | DATA_W | Read data, valid with memAck |

## Verification
A wrong valid bit or a misplaced register value surfaces at the ports in one of two ways. Most often it appears at the next add, which adds the wrong pair or reads memory a wrong number of times. It can also appear at the next pop, which exposes a stale top. A stack-pointer slip shows at once on spOut and later as a sum built from the wrong memory words. The bench therefore checks top value, pointer, underflow and the count and address of memory accesses after every command, so a corruption is caught within the command that causes it or the first add that consumes it.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_ADD  = 2'd2,
    OP_NOP  = 2'd3
  } stcOp_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2,
    ST_EXEC  = 2'd3
  } stcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pushOp;
    logic popA;
    logic popB;
    logic popMem;
    logic addOp;
    logic fillLd;
    logic spillDone;
  } stcCtl_t;

endpackage

// File: rtl/stc_datapath.sv
module stc_datapath
  import stc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stcCtl_t           ctl,
  input  logic [DATA_W-1:0] opData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              aValid,
  output logic              bValid,
  output logic [DATA_W-1:0] bReg,
  output logic [ADDR_W:0]   depth,
  output logic              topValid,
  output logic [DATA_W-1:0] topData
);

  localparam int DEPTH_W = ADDR_W + 1;

  logic [DATA_W-1:0] aReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg   <= '0;
      bReg   <= '0;
      aValid <= 1'b0;
      bValid <= 1'b0;
    end else if (ctl.pushOp) begin
      if (aValid) begin
        bReg   <= aReg;
        bValid <= 1'b1;
      end
      aReg   <= opData;
      aValid <= 1'b1;
    end else if (ctl.popA) begin
      aValid <= 1'b0;
    end else if (ctl.popB) begin
      bValid <= 1'b0;
    end else if (ctl.fillLd) begin
      if (!aValid) begin
        aValid <= 1'b1;
        if (bValid) begin
          aReg <= bReg;
          bReg <= memRdata;
        end else begin
          aReg <= memRdata;
        end
      end else begin
        bReg   <= memRdata;
        bValid <= 1'b1;
      end
    end else if (ctl.addOp) begin
      bReg   <= aReg + bReg;
      aValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth <= '0;
    end else if (ctl.spillDone) begin
      depth <= depth + DEPTH_W'(1);
    end else if (ctl.popMem || ctl.fillLd) begin
      depth <= depth - DEPTH_W'(1);
    end
  end

  assign topValid = aValid | bValid;
  assign topData  = aValid ? aReg : bReg;

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pushOp |=> (aValid && topData == $past(opData)));  // R2
  AST_ADD_LEAVES_B: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addOp |=> (!aValid && bValid));  // R6
  AST_FILL_DEC: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillLd |=> (depth == $past(depth) - DEPTH_W'(1)));  // R7

endmodule

// File: rtl/stc_control.sv
module stc_control
  import stc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              aValid,
  input  logic              bValid,
  input  logic [DATA_W-1:0] bReg,
  input  logic [ADDR_W:0]   depth,
  input  logic              memAck,
  output logic              cmdReady,
  output stcCtl_t           ctl,
  output logic [DATA_W-1:0] opData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              underflow
);

  localparam int DEPTH_W = ADDR_W + 1;

  stcState_e         state, stateNext;
  logic [DATA_W-1:0] heldData;
  logic              fire;
  logic              haveOne, haveTwo;
  logic              ufNext;
  stcOp_e            op;

  assign op       = stcOp_e'(cmdOp);
  assign cmdReady = (state == ST_IDLE);
  assign fire     = cmdValid && cmdReady;
  assign opData   = (state == ST_IDLE) ? cmdData : heldData;

  assign haveOne = aValid || bValid || (depth != '0);
  assign haveTwo = (aValid && bValid)
                || ((aValid || bValid) && (depth != '0))
                || (depth > DEPTH_W'(1));

  always_comb begin
    stateNext = state;
    ctl       = '0;
    ufNext    = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    memAddr   = '0;
    unique case (state)
      ST_IDLE: begin
        if (fire) begin
          unique case (op)
            OP_PUSH: begin
              if (aValid && bValid) stateNext  = ST_SPILL;
              else                  ctl.pushOp = 1'b1;
            end
            OP_POP: begin
              if (aValid)            ctl.popA   = 1'b1;
              else if (bValid)       ctl.popB   = 1'b1;
              else if (depth != '0)  ctl.popMem = 1'b1;
              else                   ufNext     = 1'b1;
            end
            OP_ADD: begin
              if (!haveTwo)               ufNext    = 1'b1;
              else if (aValid && bValid)  ctl.addOp = 1'b1;
              else                        stateNext = ST_FILL;
            end
            default: ;
          endcase
        end
      end
      ST_SPILL: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        memAddr = depth[ADDR_W-1:0];
        if (memAck) begin
          ctl.spillDone = 1'b1;
          ctl.pushOp    = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      ST_FILL: begin
        memReq  = 1'b1;
        memAddr = depth[ADDR_W-1:0] - ADDR_W'(1);
        if (memAck) begin
          ctl.fillLd = 1'b1;
          if (aValid || bValid) stateNext = ST_EXEC;
        end
      end
      ST_EXEC: begin
        ctl.addOp = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memWdata = bReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      heldData  <= '0;
      underflow <= 1'b0;
    end else begin
      state     <= stateNext;
      underflow <= ufNext;
      if (fire) heldData <= cmdData;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr)));  // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cmdReady);  // R9
  AST_UF_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> $past(fire));  // R8
  AST_UNDER_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (fire && op == OP_POP && !aValid && !bValid && depth == '0) |=> underflow);  // R8

endmodule

// File: rtl/stack_top_cache.sv
module stack_top_cache
  import stc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  output logic              topValid,
  output logic [DATA_W-1:0] topData,
  output logic              underflow,
  output logic [ADDR_W-1:0] spOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);

  stcCtl_t           ctl;
  logic [DATA_W-1:0] opData;
  logic              aValid, bValid;
  logic [DATA_W-1:0] bReg;
  logic [ADDR_W:0]   depth;

  stc_control #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdData  (cmdData),
    .aValid   (aValid),
    .bValid   (bValid),
    .bReg     (bReg),
    .depth    (depth),
    .memAck   (memAck),
    .cmdReady (cmdReady),
    .ctl      (ctl),
    .opData   (opData),
    .memReq   (memReq),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .underflow(underflow)
  );

  stc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .opData   (opData),
    .memRdata (memRdata),
    .aValid   (aValid),
    .bValid   (bValid),
    .bReg     (bReg),
    .depth    (depth),
    .topValid (topValid),
    .topData  (topData)
  );

  assign spOut = depth[ADDR_W-1:0] - ADDR_W'(1);

  AST_UF_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> ($stable(spOut) && $stable(topValid) && !memReq));  // R8
  AST_TOPVALID_SRC: assert property (@(posedge clk) disable iff (!rstN)
    topValid == (aValid || bValid));  // R11

endmodule

// File: tb/stack_top_cache_tb_top.sv
module stack_top_cache_tb_top;

  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [1:0]    cmdOp = '0;
  logic [DW-1:0] cmdData = '0;
  logic          topValid;
  logic [DW-1:0] topData;
  logic          underflow;
  logic [AW-1:0] spOut;
  logic          memReq, memWe, memAck;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;

  always #5 clk = ~clk;

  stack_top_cache #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdData(cmdData), .topValid(topValid), .topData(topData),
    .underflow(underflow), .spOut(spOut), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  // memory model: acknowledges one cycle after a request is seen
  logic [DW-1:0] mem [256];
  int            rdCnt, wrCnt;
  logic [AW-1:0] lastWrAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRdata <= '0;
    end else if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        mem[memAddr] <= memWdata;
        lastWrAddr   <= memAddr;
        wrCnt        <= wrCnt + 1;
      end else begin
        memRdata <= mem[memAddr];
        rdCnt    <= rdCnt + 1;
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  typedef struct {
    string         tag;
    logic          tv;
    logic [DW-1:0] td;
    logic [AW-1:0] sp;
    logic          uf;
    int            nRd;
    int            nWr;
    logic [AW-1:0] wrAddr;
  } expItem_t;

  expItem_t expQ[$];
  int       testsRun = 0;
  int       testsFailed = 0;
  logic     ufSeen;
  event     doneEv;

  // reference stack, bottom first
  logic [DW-1:0] stk[$];
  int            cached = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input logic [DW-1:0] d, input string tag);
    expItem_t e;
    int memN;
    logic [DW-1:0] x, y;
    e.tag = tag; e.uf = 1'b0; e.nRd = 0; e.nWr = 0; e.wrAddr = '0;
    memN = stk.size() - cached;
    case (op)
      2'd0: begin
        if (cached == 2) begin e.nWr = 1; e.wrAddr = AW'(memN); end
        else cached++;
        stk.push_back(d);
      end
      2'd1: begin
        if (stk.size() == 0) e.uf = 1'b1;
        else begin
          if (cached > 0) cached--;
          void'(stk.pop_back());
        end
      end
      2'd2: begin
        if (stk.size() < 2) e.uf = 1'b1;
        else begin
          e.nRd = 2 - cached;
          x = stk.pop_back();
          y = stk.pop_back();
          stk.push_back(x + y);
          cached = 1;
        end
      end
      default: ;
    endcase
    e.tv = (cached > 0);
    e.td = (cached > 0) ? stk[$] : '0;
    e.sp = AW'(stk.size() - cached - 1);
    expQ.push_back(e);

    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    rdCnt = 0; wrCnt = 0;
    cmdValid = 1'b1; cmdOp = op; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    ufSeen = underflow;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    check({tag, " R8 no late underflow"}, underflow, 1'b0);
    -> doneEv;
    #1;
  endtask

  // monitor
  initial begin
    forever begin
      expItem_t e;
      @(doneEv);
      e = expQ.pop_front();
      check({e.tag, " R11 topValid"}, topValid, e.tv);
      if (e.tv) check({e.tag, " R11 topData"}, topData, e.td);
      check({e.tag, " spOut"}, spOut, e.sp);
      check({e.tag, " R8 underflow pulse"}, ufSeen, e.uf);
      check({e.tag, " reads"}, rdCnt, e.nRd);
      check({e.tag, " writes"}, wrCnt, e.nWr);
      if (e.nWr == 1) check({e.tag, " R3 spill address"}, lastWrAddr, e.wrAddr);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 topValid", topValid, 1'b0);
    check("R1 spOut", spOut, 8'hFF);
    check("R1 cmdReady", cmdReady, 1'b1);
    check("R1 underflow", underflow, 1'b0);
    check("R1 memReq", memReq, 1'b0);

    doCmd(2'd1, 16'd0, "R8 pop empty");
    doCmd(2'd2, 16'd0, "R8 add empty");
    doCmd(2'd0, 16'd5, "R2 push into empty");
    doCmd(2'd2, 16'd0, "R8 add one entry");
    doCmd(2'd0, 16'd7, "R2 push A valid");
    doCmd(2'd0, 16'd9, "R3 push spill first");
    doCmd(2'd0, 16'd11, "R3 push spill second");
    doCmd(2'd2, 16'd0, "R6 add cached");
    doCmd(2'd2, 16'd0, "R7 add one read");
    doCmd(2'd0, 16'd100, "R2 push B valid only");
    doCmd(2'd1, 16'd0, "R4 pop A");
    doCmd(2'd1, 16'd0, "R4 pop B");
    doCmd(2'd3, 16'hBEEF, "R10 reserved opcode");
    doCmd(2'd0, 16'hFFFF, "R2 push");
    doCmd(2'd0, 16'd2, "R2 push");
    doCmd(2'd0, 16'd3, "R3 push spill");
    doCmd(2'd0, 16'd4, "R3 push spill");
    doCmd(2'd1, 16'd0, "R4 pop");
    doCmd(2'd1, 16'd0, "R4 pop");
    doCmd(2'd2, 16'd0, "R7 add two reads wrap");
    doCmd(2'd1, 16'd0, "R4 pop");
    doCmd(2'd1, 16'd0, "R5 pop from memory");
    doCmd(2'd1, 16'd0, "R8 pop after drain");
    // R9 busy observation during a spill
    doCmd(2'd0, 16'd21, "R2 push");
    doCmd(2'd0, 16'd22, "R2 push");
    fork
      doCmd(2'd0, 16'd23, "R9 spill busy");
      begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R9 ready low during spill", cmdReady, 1'b0);
      end
    join
    // mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0, 2'd3: doCmd(2'd0, lfsr, "R2 R3 mixed push");
        2'd1:       doCmd(2'd1, 16'd0, "R4 R5 mixed pop");
        default:    doCmd(2'd2, 16'd0, "R6 R7 mixed add");
      endcase
    end
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule